// File: doc/BRIEF.md
# PCIe Programmed-IO Request Engine

This block lets host software issue one PCIe request at a time through a small 32-bit register window and collect the result. Software fills in a request type, a 64-bit address, a write data word and a byte-lane strobe, then writes 1 to the launch register. The engine offers that request on a valid/ready request port and holds it there until the downstream side accepts it.

For non-posted requests (the configuration read and write codes) the engine then waits for a completion carrying a 3-bit status code and a read data word. For every other type code, which is treated as posted, the request is finished as soon as it is accepted. When a request finishes, the engine raises a done flag that software clears by writing 1. A level interrupt follows the done flag unless the mask bit blocks it.

The controller is a three-state machine. `ST_IDLE` waits for a launch. Writing 1 to the launch register moves it to `ST_ISSUE`, which drives `req_valid`. In `ST_ISSUE`, acceptance of a posted request returns it to `ST_IDLE`, and acceptance of a non-posted request moves it to `ST_WAIT`. In `ST_WAIT`, a completion pulse returns it to `ST_IDLE`.

Top module: `pio_req_engine`

## Requirements
- R1: After reset, `req_valid` and `irq` are low. The launch, status and done-flag registers read 0, and the interrupt mask reads 1 (masked).
- R2: In the cycle after a launch, `req_valid` is high and the request port carries: `req_kind` from control bits 3:0, `req_nowin` from control bit 24 (unchanged), `req_addr` as {address high, address low}, `req_wdata` from the write data register and `req_strb` from strobe bits 3:0.
- R3: While `req_valid` is high and `req_ready` is low, `req_valid` stays high and the request payload does not change.
- R4: A request whose type code is 0x8, 0x9, 0xA or 0xB is non-posted. After it is accepted, the engine waits for `cpl_valid`. It then stores `cpl_code` unchanged in status bits 9:7 (0 ok, 1 unsupported, 2 retry, 4 abort, any other value kept as is). In the same edge it latches `cpl_rdata` into the read data register at offset 0x18.
- R5: A request with any other type code is posted. It finishes on the edge where it is accepted, with status code 0, and the read data register keeps its previous value.
- R6: Status bit 0 is 1 exactly when the most recently launched request was non-posted.
- R7: The launch register (offset 0x1C) reads 1 from launch until the request finishes and 0 otherwise. While the engine is busy, writes to the launch, control, address, write data and strobe registers have no effect.
- R8: Bit 0 of the done-flag register (offset 0x20) sets when a request finishes and clears when software writes 1 to it.
- R9: `irq` is high exactly when the done flag is set and mask bit 0 (offset 0x24) is 0.
- R10: A `cpl_valid` pulse that arrives while the engine is not waiting for a completion changes neither the read data, the status nor the done flag.
- R11: The registers sit at these byte offsets: 0x0 control, 0x4 status, 0x8 address low, 0xC address high, 0x10 write data, 0x14 strobe, 0x18 read data, 0x1C launch, 0x20 done flag, 0x24 mask. The writable registers read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | RAW | Register write byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | RAW | Register read byte offset |
| reg_rdata | output | 32 | Register read data (combinational) |
| req_valid | output | 1 | Request offered |
| req_ready | input | 1 | Request accepted |
| req_kind | output | 4 | Request type code |
| req_nowin | output | 1 | Bypass address-window translation flag |
| req_addr | output | 64 | Request address |
| req_wdata | output | 32 | Request write data |
| req_strb | output | 4 | Byte-lane enables |
| cpl_valid | input | 1 | Completion pulse |
| cpl_code | input | 3 | Completion status code |
| cpl_rdata | input | 32 | Completion read data |
| irq | output | 1 | Level interrupt |

## Verification
The tests cover several request shapes:
- A Type0 configuration read with a structured bus/device/function/register address, accepted after a stall. This shows that the payload is held through the stall and that the read data and done flag are captured on the completion edge.
- A Type1 configuration write, run once with each completion code 1, 2, 4 and 5. This shows that the code is stored raw rather than decoded.
- A posted write with the window-bypass bit set. This shows that the engine finishes on acceptance and leaves the read data untouched.

Further tests issue a launch and a control rewrite while busy, toggle the mask with the done flag held, and send a stray completion while idle. These separate real requests from the inputs that must be ignored.

// File: rtl/pio_pkg.sv
package pio_pkg;
    localparam int OFS_CTRL  = 'h00;
    localparam int OFS_STAT  = 'h04;
    localparam int OFS_ADLO  = 'h08;
    localparam int OFS_ADHI  = 'h0C;
    localparam int OFS_WDAT  = 'h10;
    localparam int OFS_STRB  = 'h14;
    localparam int OFS_RDAT  = 'h18;
    localparam int OFS_START = 'h1C;
    localparam int OFS_ISR   = 'h20;
    localparam int OFS_IMSK  = 'h24;

    localparam int NOWIN_BIT = 24;
    localparam int CODE_LSB  = 7;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } pio_state_e;

    // configuration read/write codes 0x8..0xB expect a completion
    function automatic logic kind_nonposted(input logic [3:0] kind);
        return kind[3:2] == 2'b10;
    endfunction
endpackage

// File: rtl/pio_fsm.sv
module pio_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    input  logic req_np,
    input  logic req_ready,
    input  logic cpl_valid,
    output logic req_valid,
    output logic busy,
    output logic fin,
    output logic fin_cpl
);
    import pio_pkg::*;

    pio_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (launch) state_d = ST_ISSUE;
            ST_ISSUE: if (req_ready) state_d = req_np ? ST_WAIT : ST_IDLE;
            ST_WAIT:  if (cpl_valid) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        req_valid = 1'b0;
        busy      = 1'b0;
        fin       = 1'b0;
        fin_cpl   = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_ISSUE: begin
                req_valid = 1'b1;
                busy      = 1'b1;
                fin       = req_ready && !req_np;
            end
            ST_WAIT: begin
                busy    = 1'b1;
                fin     = cpl_valid;
                fin_cpl = cpl_valid;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pio_regfile.sv
module pio_regfile #(
    parameter int RAW = 6,
    parameter int DW  = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [RAW-1:0] wr_addr,
    input  logic [DW-1:0]  wr_data,
    input  logic [RAW-1:0] rd_addr,
    output logic [DW-1:0]  rd_data,
    input  logic           busy,
    input  logic           fin,
    input  logic           fin_cpl,
    input  logic [2:0]     cpl_code,
    input  logic [DW-1:0]  cpl_rdata,
    output logic           launch,
    output logic           np_req,
    output logic [3:0]     kind_q,
    output logic           nowin_q,
    output logic [2*DW-1:0] addr_q,
    output logic [DW-1:0]  wdat_q,
    output logic [DW/8-1:0] strb_q,
    output logic           done_q,
    output logic           mask_q,
    output logic [DW-1:0]  rdat_q
);
    import pio_pkg::*;

    localparam int SW = DW / 8;
    localparam logic [RAW-1:0] A_CTRL  = RAW'(OFS_CTRL);
    localparam logic [RAW-1:0] A_STAT  = RAW'(OFS_STAT);
    localparam logic [RAW-1:0] A_ADLO  = RAW'(OFS_ADLO);
    localparam logic [RAW-1:0] A_ADHI  = RAW'(OFS_ADHI);
    localparam logic [RAW-1:0] A_WDAT  = RAW'(OFS_WDAT);
    localparam logic [RAW-1:0] A_STRB  = RAW'(OFS_STRB);
    localparam logic [RAW-1:0] A_RDAT  = RAW'(OFS_RDAT);
    localparam logic [RAW-1:0] A_START = RAW'(OFS_START);
    localparam logic [RAW-1:0] A_ISR   = RAW'(OFS_ISR);
    localparam logic [RAW-1:0] A_IMSK  = RAW'(OFS_IMSK);

    logic       np_q;
    logic [2:0] code_q;
    logic       open_wr;

    assign open_wr = wr_en && !busy;
    assign launch  = open_wr && (wr_addr == A_START) && wr_data[0];
    assign np_req  = kind_nonposted(kind_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q  <= '0;
            nowin_q <= 1'b0;
            addr_q  <= '0;
            wdat_q  <= '0;
            strb_q  <= '0;
        end else if (open_wr) begin
            if (wr_addr == A_CTRL) begin
                kind_q  <= wr_data[3:0];
                nowin_q <= wr_data[NOWIN_BIT];
            end
            if (wr_addr == A_ADLO) addr_q[DW-1:0]    <= wr_data;
            if (wr_addr == A_ADHI) addr_q[2*DW-1:DW] <= wr_data;
            if (wr_addr == A_WDAT) wdat_q <= wr_data;
            if (wr_addr == A_STRB) strb_q <= wr_data[SW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            np_q   <= 1'b0;
            code_q <= '0;
            rdat_q <= '0;
            done_q <= 1'b0;
            mask_q <= 1'b1;
        end else begin
            if (launch)  np_q   <= np_req;
            if (fin)     code_q <= fin_cpl ? cpl_code : 3'd0;
            if (fin_cpl) rdat_q <= cpl_rdata;
            if (fin)
                done_q <= 1'b1;
            else if (wr_en && wr_addr == A_ISR && wr_data[0])
                done_q <= 1'b0;
            if (wr_en && wr_addr == A_IMSK) mask_q <= wr_data[0];
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            A_CTRL:  begin
                rd_data[3:0]      = kind_q;
                rd_data[NOWIN_BIT] = nowin_q;
            end
            A_STAT:  begin
                rd_data[0] = np_q;
                rd_data[CODE_LSB +: 3] = code_q;
            end
            A_ADLO:  rd_data = addr_q[DW-1:0];
            A_ADHI:  rd_data = addr_q[2*DW-1:DW];
            A_WDAT:  rd_data = wdat_q;
            A_STRB:  rd_data[SW-1:0] = strb_q;
            A_RDAT:  rd_data = rdat_q;
            A_START: rd_data[0] = busy;
            A_ISR:   rd_data[0] = done_q;
            A_IMSK:  rd_data[0] = mask_q;
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/pio_req_engine.sv
module pio_req_engine #(
    parameter int RAW = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_wr,
    input  logic [RAW-1:0] reg_waddr,
    input  logic [31:0]    reg_wdata,
    input  logic [RAW-1:0] reg_raddr,
    output logic [31:0]    reg_rdata,
    output logic           req_valid,
    input  logic           req_ready,
    output logic [3:0]     req_kind,
    output logic           req_nowin,
    output logic [63:0]    req_addr,
    output logic [31:0]    req_wdata,
    output logic [3:0]     req_strb,
    input  logic           cpl_valid,
    input  logic [2:0]     cpl_code,
    input  logic [31:0]    cpl_rdata,
    output logic           irq
);
    logic        launch, np_req, busy, fin, fin_cpl;
    logic        done_flag, mask_bit;
    logic [31:0] rdata_q;

    pio_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .launch(launch), .req_np(np_req),
        .req_ready(req_ready), .cpl_valid(cpl_valid), .req_valid(req_valid),
        .busy(busy), .fin(fin), .fin_cpl(fin_cpl)
    );

    pio_regfile #(.RAW(RAW), .DW(32)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_addr(reg_waddr),
        .wr_data(reg_wdata), .rd_addr(reg_raddr), .rd_data(reg_rdata),
        .busy(busy), .fin(fin), .fin_cpl(fin_cpl), .cpl_code(cpl_code),
        .cpl_rdata(cpl_rdata), .launch(launch), .np_req(np_req),
        .kind_q(req_kind), .nowin_q(req_nowin), .addr_q(req_addr),
        .wdat_q(req_wdata), .strb_q(req_strb), .done_q(done_flag),
        .mask_q(mask_bit), .rdat_q(rdata_q)
    );

    assign irq = done_flag && !mask_bit;
endmodule

// File: rtl/pio_req_engine_chk.sv
module pio_req_engine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic [3:0]  req_kind,
    input logic [63:0] req_addr,
    input logic [31:0] req_wdata,
    input logic        busy,
    input logic        fin,
    input logic        done_flag,
    input logic        mask_bit,
    input logic        cpl_valid,
    input logic [31:0] rdata_q,
    input logic        irq
);
    assert_valid_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_addr)
            && $stable(req_kind) && $stable(req_wdata));

    assert_valid_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> busy);

    assert_done_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> done_flag);

    assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mask_bit |-> !irq);

    assert_stray_cpl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid && !busy |=> $stable(rdata_q));
endmodule

bind pio_req_engine pio_req_engine_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .fin(fin), .done_flag(done_flag), .mask_bit(mask_bit),
    .cpl_valid(cpl_valid), .rdata_q(rdata_q), .irq(irq)
);

// File: tb/sim_pio_req_engine.sv
module sim_pio_req_engine;
    localparam int RAW = 6;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           reg_wr = 1'b0;
    logic [RAW-1:0] reg_waddr = '0;
    logic [31:0]    reg_wdata = '0;
    logic [RAW-1:0] reg_raddr = '0;
    logic [31:0]    reg_rdata;
    logic           req_valid, req_nowin, irq;
    logic           req_ready = 1'b0;
    logic [3:0]     req_kind, req_strb;
    logic [63:0]    req_addr;
    logic [31:0]    req_wdata;
    logic           cpl_valid = 1'b0;
    logic [2:0]     cpl_code = '0;
    logic [31:0]    cpl_rdata = '0;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    bit ended = 0;
    logic [31:0] last_rd = '0;

    always #5 clk = ~clk;

    pio_req_engine #(.RAW(RAW)) u0 (.*);

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        reg_raddr = RAW'(a);
        #1;
        d = reg_rdata;
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_waddr = RAW'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic program_req(input logic [3:0] k, input logic nw, input logic [63:0] a,
                               input logic [31:0] d, input logic [3:0] s);
        wr('h00, {7'd0, nw, 20'd0, k});
        wr('h08, a[31:0]);
        wr('h0C, a[63:32]);
        wr('h10, d);
        wr('h14, {28'd0, s});
    endtask

    task automatic accept(input int stall);
        for (int i = 0; i < stall; i++) begin
            chk("R3 valid held in stall", req_valid, 1);
            @(negedge clk);
        end
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
    endtask

    task automatic complete(input logic [2:0] c, input logic [31:0] d);
        cpl_valid = 1'b1; cpl_code = c; cpl_rdata = d;
        @(negedge clk);
        cpl_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 req_valid", req_valid, 0);
        chk("R1 irq", irq, 0);
        rd('h1C, v); chk("R1 launch reg", v, 0);
        rd('h04, v); chk("R1 status", v, 0);
        rd('h20, v); chk("R1 done flag", v, 0);
        rd('h24, v); chk("R1 mask", v, 1);
    endtask

    task automatic t_cfg_read();
        logic [31:0] v;
        logic [63:0] a;
        a = 64'h0000_0000_0032_A040; // bus 3, dev 5, fn 2, reg 0x40
        wr('h24, 0);
        program_req(4'h8, 1'b0, a, 32'h0, 4'hF);
        rd('h00, v); chk("R11 ctrl readback", v, 32'h8);
        rd('h08, v); chk("R11 addr low readback", v, a[31:0]);
        rd('h14, v); chk("R11 strobe readback", v, 32'hF);
        wr('h1C, 1);
        chk("R2 valid", req_valid, 1);
        chk("R2 kind", req_kind, 4'h8);
        chk("R2 addr", req_addr, a);
        chk("R2 strb", req_strb, 4'hF);
        chk("R2 nowin", req_nowin, 0);
        accept(3);
        chk("R4 valid dropped", req_valid, 0);
        rd('h1C, v); chk("R7 launch reads busy", v, 1);
        rd('h20, v); chk("R4 waits for completion", v, 0);
        complete(3'd0, 32'hCAFE_F00D);
        last_rd = 32'hCAFE_F00D;
        rd('h18, v); chk("R4 read data", v, last_rd);
        rd('h04, v); chk("R6 status ok np", v, 32'h1);
        rd('h20, v); chk("R8 done set", v, 1);
        chk("R9 irq on", irq, 1);
        rd('h1C, v); chk("R7 launch cleared", v, 0);
        wr('h20, 1);
        rd('h20, v); chk("R8 w1c", v, 0);
        chk("R9 irq off", irq, 0);
    endtask

    task automatic t_codes();
        logic [31:0] v;
        logic [2:0] codes [4] = '{3'd1, 3'd2, 3'd4, 3'd5};
        for (int i = 0; i < 4; i++) begin
            program_req(4'hB, 1'b0, 64'h0010_8004, 32'h55AA_0000 + i, 4'h3);
            wr('h1C, 1);
            chk("R2 wdata", req_wdata, 32'h55AA_0000 + i);
            accept(0);
            complete(codes[i], 32'h100 + i);
            last_rd = 32'h100 + i;
            rd('h04, v); chk("R4 status code raw", v, {22'd0, codes[i], 7'd1});
            rd('h18, v); chk("R4 read data", v, last_rd);
            wr('h20, 1);
        end
    endtask

    task automatic t_posted();
        logic [31:0] v;
        program_req(4'h0, 1'b1, 64'h0000_0001_8000_0000, 32'h1357_9BDF, 4'hF);
        wr('h1C, 1);
        chk("R2 nowin passthrough", req_nowin, 1);
        chk("R2 addr high", req_addr, 64'h0000_0001_8000_0000);
        accept(1);
        rd('h1C, v); chk("R5 posted done on accept", v, 0);
        rd('h20, v); chk("R5 done flag", v, 1);
        rd('h04, v); chk("R6 posted status", v, 0);
        rd('h18, v); chk("R5 read data kept", v, last_rd);
        wr('h20, 1);
    endtask

    task automatic t_busy_ignore();
        logic [31:0] v;
        program_req(4'h9, 1'b0, 64'h0020_0000, 32'h0, 4'hF);
        wr('h1C, 1);
        wr('h00, 32'h0);
        chk("R7 ctrl write ignored when busy", req_kind, 4'h9);
        wr('h08, 32'hFFFF_0000);
        chk("R7 addr write ignored when busy", req_addr, 64'h0020_0000);
        accept(0);
        wr('h1C, 1);
        complete(3'd0, 32'h2468);
        last_rd = 32'h2468;
        rd('h1C, v); chk("R7 launch clear", v, 0);
        @(negedge clk);
        chk("R7 busy launch ignored", req_valid, 0);
        rd('h00, v); chk("R7 ctrl kept", v, 32'h9);
    endtask

    task automatic t_mask();
        logic [31:0] v;
        wr('h24, 1);
        rd('h20, v); chk("R9 flag still set", v, 1);
        chk("R9 masked irq", irq, 0);
        wr('h24, 0);
        chk("R9 unmasked irq", irq, 1);
        wr('h20, 1);
        chk("R8 clear drops irq", irq, 0);
    endtask

    task automatic t_stray();
        logic [31:0] v;
        complete(3'd4, 32'hDEAD_BEEF);
        rd('h18, v); chk("R10 read data", v, last_rd);
        rd('h20, v); chk("R10 done flag", v, 0);
        rd('h04, v); chk("R10 status", v, 32'h1);
        chk("R10 irq", irq, 0);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !ended) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cfg_read();
        t_codes();
        t_posted();
        t_busy_ignore();
        t_mask();
        t_stray();
        finish_run();
    end
endmodule